// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two 32-bit operands over a fixed run of clock cycles and returns a 64-bit product. One double-width product register holds the running partial sum in its upper half. Its lower half starts out holding the multiplier. On each step the block looks at the lowest product bit. If that bit is set, it adds the stored multiplicand into the upper half. It then shifts the whole register one place to the right, and the carry of the addition enters at the top. After one step per multiplier bit, the register holds the complete product.

A caller presents both operands and a mode bit, then pulses a start request. The block raises busy while it works and drops it on completion, giving a one-cycle done pulse. The product stays on the high and low output words until the next accepted start. In signed mode the operands are first reduced to magnitudes and multiplied as unsigned values. The full product is negated at the end when exactly one operand was negative.

Top module: `smul_seq`

## Requirements
- R1: While idle (busy low), a start request is accepted on the clock edge that samples it, and busy is high in the following cycle.
- R2: After an accepted start, busy stays high for exactly WIDTH cycles (32 by default). Done is then high for exactly one cycle, during which busy is low. Busy and done are never high together.
- R3: With signed_i low, {hi_o, lo_o} equals the unsigned product of mcand_i and mplier_i as captured at the accepted start. hi_o carries product bits 63..32 and lo_o carries bits 31..0 (for example 2 times 3 gives hi 0, lo 6).
- R4: With signed_i high, both operands are read as two's complement and {hi_o, lo_o} is their 64-bit two's complement product. This includes the most negative operand value (0x80000000) and zero operands.
- R5: With signed_i low, an operand whose top bit is set counts as a large positive value (for example 0xFFFFFFFF squared gives 0xFFFFFFFE_00000001).
- R6: A start request while busy is high has no effect: the run in progress keeps its operands, its result and its WIDTH-cycle length.
- R7: While idle and with no start request, hi_o, lo_o and busy do not change, whatever the operand and mode inputs do.
- R8: A start request in the cycle where done is high is accepted: busy is high in the next cycle, and the new run completes with its own correct product.
- R9: During reset busy_o and done_o are low and hi_o and lo_o are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a multiplication |
| signed_i | input | 1 | 1: operands are two's complement; 0: unsigned |
| mcand_i | input | 32 | Multiplicand operand |
| mplier_i | input | 32 | Multiplier operand |
| busy_o | output | 1 | High while a multiplication is running |
| done_o | output | 1 | One-cycle completion pulse |
| hi_o | output | 32 | Upper word of the product |
| lo_o | output | 32 | Lower word of the product |

## Verification
Two functions can share one cycle: the completion pulse of one run and the acceptance of the next start. The bench raises start in the very cycle it observes done high. It then judges that busy rises and done falls one cycle later, that the second run still lasts exactly 32 cycles, and that it yields its own product. A second coincidence is also covered: the final add-and-shift and the sign negation both fall on the last step. Signed vectors with mixed operand signs, including the most negative value, show whether the negation is applied to the finished product.

// File: rtl/smul_pkg.sv
package smul_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } smul_phase_e;

endpackage

// File: rtl/smul_mag.sv
// Reduces an operand to its magnitude when signed interpretation is enabled.
module smul_mag #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] val_i,
    input  logic             signed_i,
    output logic [WIDTH-1:0] mag_o,
    output logic             neg_o
);
    always_comb begin
        neg_o = signed_i & val_i[WIDTH-1];
        mag_o = neg_o ? (~val_i + WIDTH'(1)) : val_i;
    end
endmodule

// File: rtl/smul_step.sv
// One add-and-shift iteration on the double-width product register.
module smul_step #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [2*WIDTH-1:0] prod_i,
    input  logic [WIDTH-1:0]   mcand_i,
    output logic [2*WIDTH-1:0] prod_o
);
    logic [WIDTH:0] sum;

    always_comb begin
        sum    = {1'b0, prod_i[2*WIDTH-1:WIDTH]}
               + (prod_i[0] ? {1'b0, mcand_i} : '0);
        prod_o = {sum, prod_i[WIDTH-1:1]};
    end
endmodule

// File: rtl/smul_negate.sv
// Conditional two's complement negation of the finished product.
module smul_negate #(
    parameter int unsigned PW = 64
) (
    input  logic [PW-1:0] val_i,
    input  logic          neg_i,
    output logic [PW-1:0] val_o
);
    always_comb begin
        val_o = neg_i ? (~val_i + PW'(1)) : val_i;
    end
endmodule

// File: rtl/smul_seq.sv
module smul_seq #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             signed_i,
    input  logic [WIDTH-1:0] mcand_i,
    input  logic [WIDTH-1:0] mplier_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] hi_o,
    output logic [WIDTH-1:0] lo_o
);
    import smul_pkg::*;

    localparam int unsigned PW = 2 * WIDTH;
    localparam int unsigned CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST_STEP = CW'(WIDTH - 1);

    typedef struct packed {
        smul_phase_e     phase;
        logic            done;
        logic            neg;
        logic [CW-1:0]   step;
        logic [WIDTH-1:0] mcand;
        logic [PW-1:0]   prod;
    } smul_state_t;

    smul_state_t st_d, st_q;

    logic [WIDTH-1:0] opnd_val [2];
    logic [WIDTH-1:0] opnd_mag [2];
    logic [1:0]       opnd_neg;
    logic [PW-1:0]    prod_step;
    logic [PW-1:0]    prod_final;

    assign opnd_val[0] = mcand_i;
    assign opnd_val[1] = mplier_i;

    for (genvar g = 0; g < 2; g++) begin : g_mag
        smul_mag #(.WIDTH(WIDTH)) i_mag (
            .val_i    (opnd_val[g]),
            .signed_i (signed_i),
            .mag_o    (opnd_mag[g]),
            .neg_o    (opnd_neg[g])
        );
    end

    smul_step #(.WIDTH(WIDTH)) i_step (
        .prod_i  (st_q.prod),
        .mcand_i (st_q.mcand),
        .prod_o  (prod_step)
    );

    smul_negate #(.PW(PW)) i_negate (
        .val_i (prod_step),
        .neg_i (st_q.neg),
        .val_o (prod_final)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.phase = PH_RUN;
                    st_d.mcand = opnd_mag[0];
                    st_d.prod  = {{WIDTH{1'b0}}, opnd_mag[1]};
                    st_d.neg   = opnd_neg[0] ^ opnd_neg[1];
                    st_d.step  = '0;
                end
            end
            PH_RUN: begin
                st_d.step = st_q.step + CW'(1);
                if (st_q.step == LAST_STEP) begin
                    st_d.prod  = prod_final;
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                end else begin
                    st_d.prod  = prod_step;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{phase: PH_IDLE, done: 1'b0, neg: 1'b0, step: '0,
                      mcand: '0, prod: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = (st_q.phase == PH_RUN);
    assign done_o = st_q.done;
    assign hi_o   = st_q.prod[PW-1:WIDTH];
    assign lo_o   = st_q.prod[WIDTH-1:0];

endmodule

// File: rtl/smul_checker.sv
module smul_checker #(
    parameter int unsigned WIDTH = 32
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             start_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [WIDTH-1:0] hi_o,
    input logic [WIDTH-1:0] lo_o
);
    logic [31:0] run_len;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            run_len <= '0;
        end else if (start_i && !busy_o) begin
            run_len <= '0;
        end else if (busy_o) begin
            run_len <= run_len + 32'd1;
        end
    end

    assert_start_taken_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i && !busy_o |=> busy_o);

    assert_run_length_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> run_len == 32'(WIDTH));

    assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_busy_done_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(busy_o && done_o));

    assert_run_continues_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o && (run_len != 32'(WIDTH - 1)) |=> busy_o);

    assert_idle_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o && !start_i |=> !busy_o && $stable(hi_o) && $stable(lo_o));

endmodule

bind smul_seq smul_checker #(.WIDTH(WIDTH)) i_smul_checker (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .hi_o    (hi_o),
    .lo_o    (lo_o)
);

// File: tb/test_smul_seq.sv
module test_smul_seq;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;
    localparam int NVEC = 12;

    // {signed mode, multiplicand, multiplier}
    localparam logic [64:0] VEC [NVEC] = '{
        {1'b0, 32'd2,          32'd3},
        {1'b0, 32'd0,          32'hFFFF_FFFF},
        {1'b0, 32'hFFFF_FFFF,  32'hFFFF_FFFF},
        {1'b0, 32'h8000_0000,  32'd2},
        {1'b0, 32'h1234_5678,  32'h9ABC_DEF0},
        {1'b1, 32'hFFFF_FFF9,  32'd2},
        {1'b1, 32'd7,          32'hFFFF_FFFE},
        {1'b1, 32'hFFFF_FFF9,  32'hFFFF_FFFE},
        {1'b1, 32'h8000_0000,  32'h8000_0000},
        {1'b1, 32'h8000_0000,  32'd1},
        {1'b1, 32'd0,          32'hFFFF_FFFB},
        {1'b1, 32'h7FFF_FFFF,  32'h7FFF_FFFF}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic mode = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic busy, done;
    logic [W-1:0] hi, lo;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smul_seq #(.WIDTH(W)) i_smul_seq (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .signed_i(mode),
        .mcand_i(a), .mplier_i(b), .busy_o(busy), .done_o(done),
        .hi_o(hi), .lo_o(lo)
    );

    function automatic logic [63:0] ref_mul(logic s, logic [31:0] x, logic [31:0] y);
        logic signed [63:0] sx, sy;
        if (s) begin
            sx = $signed({{32{x[31]}}, x});
            sy = $signed({{32{y[31]}}, y});
            return 64'(sx * sy);
        end
        return {32'b0, x} * {32'b0, y};
    endfunction

    task automatic check(input logic ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the negedge after the accepting edge
    task automatic launch(input logic s, input logic [31:0] x, input logic [31:0] y);
        mode = s; a = x; b = y; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        a = ~x; b = ~y; mode = ~s;   // operands must have been captured
        check(busy == 1'b1, "R1", 64'(busy), 64'd1);
    endtask

    // waits for done; optional intruding start during the run (R6)
    task automatic finish_run(input logic [63:0] exp, input string req, input bit intrude);
        int n = 0;
        while (!done && n < 200) begin
            if (intrude && n == 5) begin
                start = 1'b1; a = 32'hDEAD_BEEF; b = 32'h1357_9BDF;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        check(n == W, "R2 latency", 64'(n), 64'(W));
        check(busy == 1'b0, "R2 busy low at done", 64'(busy), 64'd0);
        check({hi, lo} == exp, req, {hi, lo}, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [63:0] exp;
        logic [63:0] held;
        // R9 reset state
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R9 flags", {62'b0, busy, done}, 64'd0);
        check({hi, lo} == 64'd0, "R9 product", {hi, lo}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R3 unsigned, R5 large unsigned, R4 signed
        for (int i = 0; i < NVEC; i++) begin
            string tag;
            exp = ref_mul(VEC[i][64], VEC[i][63:32], VEC[i][31:0]);
            if (VEC[i][64]) tag = "R4 signed product";
            else if (VEC[i][63] || VEC[i][31]) tag = "R5 unsigned high operand";
            else tag = "R3 unsigned product";
            launch(VEC[i][64], VEC[i][63:32], VEC[i][31:0]);
            finish_run(exp, tag, 1'b0);
            @(negedge clk);
            check(done == 1'b0, "R2 single pulse", 64'(done), 64'd0);
            @(negedge clk);
        end

        // R6: start while busy is ignored
        exp = ref_mul(1'b0, 32'd1000, 32'd77);
        launch(1'b0, 32'd1000, 32'd77);
        finish_run(exp, "R6 intruding start ignored", 1'b1);
        start = 1'b0;

        // R7: outputs hold while idle with changing inputs
        held = {hi, lo};
        repeat (6) begin
            @(negedge clk);
            a = a + 32'd12345; b = ~b; mode = ~mode;
        end
        check({hi, lo} == held, "R7 hold", {hi, lo}, held);
        check(busy == 1'b0, "R7 stays idle", 64'(busy), 64'd0);

        // R8: start in the done cycle
        exp = ref_mul(1'b1, 32'hFFFF_FF00, 32'd3);
        launch(1'b1, 32'hFFFF_FF00, 32'd3);
        finish_run(exp, "R8 first run", 1'b0);
        exp = ref_mul(1'b0, 32'h0001_0001, 32'h0001_0001);
        check(done == 1'b1, "R8 done seen", 64'(done), 64'd1);
        launch(1'b0, 32'h0001_0001, 32'h0001_0001);
        check(done == 1'b0, "R8 done dropped", 64'(done), 64'd0);
        finish_run(exp, "R8 back-to-back product", 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule